// File: doc/BRIEF.md
# Programmable Clock Channel Divider with Synchronized Restart

This block divides an input clock for one output channel. The high and low phases of the divided clock are set separately, so the ratio runs from 2 to 32, and a bypass path gives a ratio of 1. A coarse phase offset, counted in input clock cycles, delays the first edge after a restart. A start-level bit picks the level the output takes while it is parked and the level it begins with after a restart. An optional half-cycle extension gives a 50% duty cycle for odd ratios.

A chip-level synchronization level input and a software sync bit both park the output at a static level. The software bit has the opposite polarity to the pin. When the sync is released, the channel restarts after a fixed pipeline delay, so every channel that obeys the sync starts on the same input edge. A channel can be set to ignore the sync. Only a channel that ignores the sync can be forced high. After reset the block runs the restart sequence by itself, so the outputs line up at power-up without a sync pulse.

Top module: `clk_chan_div`

## Requirements
- R1: While `rstN` is low the output is 0. After `rstN` rises with no sync asserted, the output holds the start level and first changes on rising edge number 16 + phase + first-length, counted from the first rising edge after the release. First-length is the high length when `startHigh` is 1 and the low length otherwise.
- R2: With correction off, the output is high for `highCode`+1 input cycles and low for `lowCode`+1 input cycles (codes 0..15, so 1..16 cycles each).
- R3: With `dccEnable` at 1 and total N = (`highCode`+1)+(`lowCode`+1), an even N gives N/2 cycles high and N/2 cycles low. An odd N gives (N−1)/2 cycles plus one half cycle high and the same low, because the high level is held until the next falling input edge.
- R4: While the sync is asserted (`syncN` low or `softSync` high), with `ignoreSync` and `bypass` low, the output stays at `startHigh` from the third rising edge on.
- R5: After the sync is released, the output holds `startHigh` and first changes on rising edge number 16 + phase + first-length, counted from the first rising edge after the release. This is never fewer than 14 cycles.
- R6: Each unit of `phaseCode` (0..15) delays that first change by one input cycle.
- R7: A 1-to-0 change of `softSync` starts the same restart as a rising `syncN`.
- R8: With `ignoreSync` at 1, the channel keeps dividing with the R2 timing while the sync is asserted.
- R9: `forceHigh` drives the output to 1 only when `ignoreSync` is also 1. With `ignoreSync` at 0 it has no effect.
- R10: With `bypass` at 1 the output follows the input clock and the counter is parked. After `bypass` falls with no sync asserted, the first change comes on rising edge number 14 + phase + first-length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | Input clock to be divided |
| rstN | input | 1 | Asynchronous active-low reset |
| syncN | input | 1 | Chip-level sync level, low parks the output |
| softSync | input | 1 | Software sync bit, 1 parks the output, a fall restarts it |
| highCode | input | 4 | High phase length minus one |
| lowCode | input | 4 | Low phase length minus one |
| phaseCode | input | 4 | Extra restart delay in input cycles |
| startHigh | input | 1 | Parked level and first level after a restart |
| dccEnable | input | 1 | Balances the high and low phases, with a half-cycle step for odd ratios |
| bypass | input | 1 | Passes the input clock straight through |
| ignoreSync | input | 1 | Channel disregards both sync sources |
| forceHigh | input | 1 | Output held at 1 when the sync is ignored |
| divOut | output | 1 | Divided clock |

## Verification
The tests are directed and check the output only. A wrong count reload shows up in the first full high or low phase after a restart, measured to half-cycle resolution. A synchronizer or wait counter that is off by one moves the first output edge by whole cycles, so the bench counts the exact rising edge of that change. A wrong parking decision shows within three cycles as a level other than the start level while the sync is held. A broken half-cycle path shows on the first odd-ratio period, where the high and low phases stop being equal.

// File: rtl/clk_chan_div_pkg.sv
package clk_chan_div_pkg;

  typedef enum logic [1:0] {
    ST_PARK = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } ctlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic park;    // hold the level at the start value
    logic launch;  // load the first phase length
    logic run;     // count and toggle
  } divStrobe_t;

endpackage

// File: rtl/clk_chan_div_ctrl.sv
module clk_chan_div_ctrl
  import clk_chan_div_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int LATENCY = 14
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              holdRaw,
  input  logic              ignoreSync,
  input  logic              bypass,
  input  logic [CODE_W-1:0] phaseCode,
  output divStrobe_t        strobe
);

  localparam int SYNC_STAGES = 2;
  localparam int WAIT_W      = $clog2(LATENCY + (1 << CODE_W)) + 1;

  logic [SYNC_STAGES-1:0] syncPipe;
  logic                   holdNow;
  logic [WAIT_W-1:0]      waitCnt;
  logic [WAIT_W-1:0]      waitLoad;
  ctlState_e              state;

  // Two-stage synchronizer, reset to "held" so power-up runs a restart
  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) syncPipe <= '1;
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], holdRaw};
  end

  assign holdNow  = (syncPipe[SYNC_STAGES-1] & ~ignoreSync) | bypass;
  // The synchronizer already took SYNC_STAGES cycles of the latency
  assign waitLoad = WAIT_W'(LATENCY - SYNC_STAGES) + WAIT_W'(phaseCode);

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PARK;
      waitCnt <= '0;
    end else if (holdNow) begin
      state   <= ST_PARK;
    end else begin
      case (state)
        ST_PARK: begin
          state   <= ST_WAIT;
          waitCnt <= waitLoad;
        end
        ST_WAIT: begin
          if (waitCnt == '0) state <= ST_RUN;
          else               waitCnt <= waitCnt - WAIT_W'(1);
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    strobe.park   = holdNow | (state == ST_PARK);
    strobe.launch = ~holdNow & (state == ST_WAIT) & (waitCnt == '0);
    strobe.run    = ~holdNow & (state == ST_RUN);
  end

endmodule

// File: rtl/clk_chan_div_dp.sv
module clk_chan_div_dp
  import clk_chan_div_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  divStrobe_t        strobe,
  input  logic [CODE_W-1:0] highCode,
  input  logic [CODE_W-1:0] lowCode,
  input  logic              startHigh,
  input  logic              dccEnable,
  input  logic              bypass,
  input  logic              forceHigh,
  input  logic              ignoreSync,
  output logic              divOut
);

  localparam int CNT_W = CODE_W + 1;
  localparam int SUM_W = CNT_W + 1;

  logic [CNT_W-1:0] highLen, lowLen, highEff, lowEff;
  logic [CNT_W-1:0] firstLen, nextLen, cnt;
  logic [SUM_W-1:0] total, halfTotal;
  logic             halfExt, level, levelNeg, shaped;

  always_comb begin
    highLen   = CNT_W'(highCode) + CNT_W'(1);
    lowLen    = CNT_W'(lowCode) + CNT_W'(1);
    total     = SUM_W'(highLen) + SUM_W'(lowLen);
    halfTotal = total >> 1;
    highEff   = dccEnable ? CNT_W'(halfTotal) : highLen;
    lowEff    = dccEnable ? CNT_W'(total - halfTotal) : lowLen;
    halfExt   = dccEnable & total[0];
    firstLen  = startHigh ? highEff : lowEff;
    nextLen   = level ? lowEff : highEff;
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (strobe.park) begin
      level <= startHigh;
    end else if (strobe.launch) begin
      cnt   <= firstLen - CNT_W'(1);
    end else if (strobe.run) begin
      if (cnt == '0) begin
        level <= ~level;
        cnt   <= nextLen - CNT_W'(1);
      end else begin
        cnt   <= cnt - CNT_W'(1);
      end
    end
  end

  // Falling-edge copy stretches the high phase by half a cycle
  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) levelNeg <= 1'b0;
    else       levelNeg <= level;
  end

  assign shaped = level | (halfExt & levelNeg);
  assign divOut = bypass ? clkIn : ((forceHigh & ignoreSync) ? 1'b1 : shaped);

endmodule

// File: rtl/clk_chan_div.sv
module clk_chan_div
  import clk_chan_div_pkg::*;
#(
  parameter int CODE_W  = 4,
  parameter int LATENCY = 14
) (
  input  logic              clkIn,
  input  logic              rstN,
  input  logic              syncN,
  input  logic              softSync,
  input  logic [CODE_W-1:0] highCode,
  input  logic [CODE_W-1:0] lowCode,
  input  logic [CODE_W-1:0] phaseCode,
  input  logic              startHigh,
  input  logic              dccEnable,
  input  logic              bypass,
  input  logic              ignoreSync,
  input  logic              forceHigh,
  output logic              divOut
);

  divStrobe_t strobe;
  logic       holdRaw;

  assign holdRaw = ~syncN | softSync;

  clk_chan_div_ctrl #(.CODE_W(CODE_W), .LATENCY(LATENCY)) u_ctrl (
    .clkIn      (clkIn),
    .rstN       (rstN),
    .holdRaw    (holdRaw),
    .ignoreSync (ignoreSync),
    .bypass     (bypass),
    .phaseCode  (phaseCode),
    .strobe     (strobe)
  );

  clk_chan_div_dp #(.CODE_W(CODE_W)) u_dp (
    .clkIn      (clkIn),
    .rstN       (rstN),
    .strobe     (strobe),
    .highCode   (highCode),
    .lowCode    (lowCode),
    .startHigh  (startHigh),
    .dccEnable  (dccEnable),
    .bypass     (bypass),
    .forceHigh  (forceHigh),
    .ignoreSync (ignoreSync),
    .divOut     (divOut)
  );

endmodule

// File: rtl/clk_chan_div_chk.sv
module clk_chan_div_chk #(
  parameter int CODE_W  = 4,
  parameter int LATENCY = 14
) (
  input logic              clkIn,
  input logic              rstN,
  input logic              syncN,
  input logic              softSync,
  input logic [CODE_W-1:0] highCode,
  input logic [CODE_W-1:0] lowCode,
  input logic [CODE_W-1:0] phaseCode,
  input logic              startHigh,
  input logic              dccEnable,
  input logic              bypass,
  input logic              ignoreSync,
  input logic              forceHigh,
  input logic              divOut
);

  localparam int CFG_W = 3 * CODE_W + 2;

  logic             rawHold, cfgSame, okWin, validWin, prevOut;
  logic [2:0]       sinceRst, holdCnt;
  logic [5:0]       relCnt, runLen;
  logic [CFG_W-1:0] cfgNow, prevCfg;

  assign rawHold = ~syncN | softSync;
  assign cfgNow  = {highCode, lowCode, phaseCode, startHigh, dccEnable};
  assign cfgSame = (cfgNow == prevCfg);
  assign okWin   = ~ignoreSync & ~bypass & ~forceHigh & cfgSame;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      holdCnt  <= '0;
      relCnt   <= '0;
      validWin <= 1'b0;
      runLen   <= '0;
      prevOut  <= 1'b0;
      prevCfg  <= '0;
    end else begin
      if (sinceRst != 3'd7) sinceRst <= sinceRst + 3'd1;
      holdCnt <= rawHold ? ((holdCnt == 3'd7) ? holdCnt : holdCnt + 3'd1) : 3'd0;
      relCnt  <= rawHold ? 6'd0 : ((relCnt == 6'd63) ? relCnt : relCnt + 6'd1);
      if (!okWin)       validWin <= 1'b0;
      else if (rawHold) validWin <= (holdCnt >= 3'd3);
      prevOut <= divOut;
      runLen  <= (divOut == prevOut) ? ((runLen == 6'd63) ? runLen : runLen + 6'd1) : 6'd0;
      prevCfg <= cfgNow;
    end
  end

  AST_FORCE_WITH_IGNORE: assert property (@(posedge clkIn) disable iff (!rstN)
    (ignoreSync && forceHigh && !bypass) |-> divOut); // R9

  AST_HOLD_STATIC: assert property (@(posedge clkIn) disable iff (!rstN)
    (sinceRst >= 3'd4 && $past(rawHold, 3) && !$past(ignoreSync) && !ignoreSync &&
     !bypass && $stable(startHigh)) |-> (divOut == startHigh)); // R4

  AST_RESTART_QUIET: assert property (@(posedge clkIn) disable iff (!rstN)
    (sinceRst >= 3'd4 && validWin && okWin && relCnt >= 6'd1 &&
     relCnt <= 6'(LATENCY)) |-> $stable(divOut)); // R5

  AST_PHASE_BOUND: assert property (@(posedge clkIn) disable iff (!rstN)
    (validWin && okWin && relCnt >= 6'd50) |-> (runLen <= 6'd15)); // R2

endmodule

bind clk_chan_div clk_chan_div_chk #(.CODE_W(CODE_W), .LATENCY(LATENCY)) u_chk (
  .clkIn      (clkIn),
  .rstN       (rstN),
  .syncN      (syncN),
  .softSync   (softSync),
  .highCode   (highCode),
  .lowCode    (lowCode),
  .phaseCode  (phaseCode),
  .startHigh  (startHigh),
  .dccEnable  (dccEnable),
  .bypass     (bypass),
  .ignoreSync (ignoreSync),
  .forceHigh  (forceHigh),
  .divOut     (divOut)
);

// File: tb/clk_chan_div_bench.sv
`timescale 1ns/1ps
module clk_chan_div_bench;

  localparam int PERIOD = 10;
  localparam int QTR    = 2;

  logic       clkIn = 1'b0;
  logic       rstN, syncN, softSync, startHigh, dccEnable, bypass, ignoreSync, forceHigh;
  logic [3:0] highCode, lowCode, phaseCode;
  logic       divOut;

  int checks = 0;
  int fails  = 0;

  always #(PERIOD/2) clkIn = ~clkIn;

  clk_chan_div u_clk_chan_div (
    .clkIn(clkIn), .rstN(rstN), .syncN(syncN), .softSync(softSync),
    .highCode(highCode), .lowCode(lowCode), .phaseCode(phaseCode),
    .startHigh(startHigh), .dccEnable(dccEnable), .bypass(bypass),
    .ignoreSync(ignoreSync), .forceHigh(forceHigh), .divOut(divOut)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic halfTick();
    @(clkIn);
    #QTR;
  endtask

  task automatic cycleTick();
    @(posedge clkIn);
    #QTR;
  endtask

  task automatic atLowPhase();
    @(negedge clkIn);
    #QTR;
  endtask

  // Counts rising edges after a release until the output leaves the start level
  task automatic countToEdge(int exp, string tag);
    int   n = 0;
    logic lvl = startHigh;
    for (int i = 0; i < 100; i++) begin
      cycleTick();
      n++;
      if (divOut !== lvl) break;
    end
    check(tag, n, exp);
  endtask

  // Measures one high and one low phase in half cycles
  task automatic measureLevels(int expHi, int expLo, string tag);
    int   hi = 0;
    int   lo = 0;
    logic prev = divOut;
    for (int i = 0; i < 300; i++) begin
      halfTick();
      if (prev == 1'b0 && divOut == 1'b1) break;
      prev = divOut;
    end
    hi = 1;
    for (int i = 0; i < 200; i++) begin
      halfTick();
      if (divOut != 1'b1) break;
      hi++;
    end
    lo = 1;
    for (int i = 0; i < 200; i++) begin
      halfTick();
      if (divOut != 1'b0) break;
      lo++;
    end
    check({tag, " high"}, hi, expHi);
    check({tag, " low"}, lo, expLo);
  endtask

  task automatic staticLevel(logic val, int halves, string tag);
    int bad = 0;
    for (int i = 0; i < halves; i++) begin
      halfTick();
      if (divOut !== val) bad++;
    end
    check(tag, bad, 0);
  endtask

  task automatic setCfg(int hc, int lc, int pc, logic sh, logic dcc);
    highCode  = 4'(hc);
    lowCode   = 4'(lc);
    phaseCode = 4'(pc);
    startHigh = sh;
    dccEnable = dcc;
  endtask

  task automatic testReset();
    rstN = 1'b0; syncN = 1'b1; softSync = 1'b0; bypass = 1'b0;
    ignoreSync = 1'b0; forceHigh = 1'b0;
    setCfg(1, 2, 0, 1'b0, 1'b0);
    repeat (3) cycleTick();
    check("R1 output low in reset", int'(divOut), 0);
    atLowPhase();
    rstN = 1'b1;
    countToEdge(19, "R1 power-up restart edge");
  endtask

  task automatic testRatio();
    atLowPhase(); setCfg(1, 2, 0, 1'b0, 1'b0);
    measureLevels(4, 6, "R2 ratio 2+3");
    atLowPhase(); setCfg(15, 15, 0, 1'b0, 1'b0);
    measureLevels(32, 32, "R2 ratio 16+16");
    atLowPhase(); setCfg(0, 0, 0, 1'b0, 1'b0);
    measureLevels(2, 2, "R2 ratio 1+1");
  endtask

  task automatic testDuty();
    atLowPhase(); setCfg(0, 1, 0, 1'b0, 1'b1);
    measureLevels(3, 3, "R3 odd ratio 3");
    atLowPhase(); setCfg(2, 3, 0, 1'b0, 1'b1);
    measureLevels(7, 7, "R3 odd ratio 7");
    atLowPhase(); setCfg(0, 4, 0, 1'b0, 1'b1);
    measureLevels(6, 6, "R3 even ratio 6");
  endtask

  task automatic testHoldRelease();
    atLowPhase(); setCfg(3, 1, 0, 1'b1, 1'b0);
    syncN = 1'b0;
    repeat (4) cycleTick();
    staticLevel(1'b1, 20, "R4 parked at start level");
    atLowPhase();
    syncN = 1'b1;
    countToEdge(20, "R5 restart edge");
    measureLevels(8, 4, "R5 ratio after restart");
  endtask

  task automatic testPhase();
    atLowPhase(); setCfg(0, 1, 5, 1'b0, 1'b0);
    syncN = 1'b0;
    repeat (6) cycleTick();
    atLowPhase();
    syncN = 1'b1;
    countToEdge(23, "R6 phase offset 5");
  endtask

  task automatic testSoftSync();
    atLowPhase(); setCfg(1, 0, 2, 1'b0, 1'b0);
    softSync = 1'b1;
    repeat (4) cycleTick();
    staticLevel(1'b0, 10, "R7 soft sync parks");
    atLowPhase();
    softSync = 1'b0;
    countToEdge(19, "R7 soft sync restart edge");
  endtask

  task automatic testIgnore();
    atLowPhase(); setCfg(1, 2, 0, 1'b0, 1'b0);
    ignoreSync = 1'b1;
    syncN = 1'b0;
    measureLevels(4, 6, "R8 runs through sync");
  endtask

  task automatic testForce();
    atLowPhase();
    forceHigh = 1'b1;
    staticLevel(1'b1, 10, "R9 forced high");
    atLowPhase();
    ignoreSync = 1'b0;
    repeat (5) cycleTick();
    staticLevel(1'b0, 10, "R9 force without ignore");
    atLowPhase();
    forceHigh = 1'b0;
    syncN = 1'b1;
    repeat (40) cycleTick();
  endtask

  task automatic testBypass();
    int bad = 0;
    atLowPhase(); setCfg(1, 2, 0, 1'b0, 1'b0);
    bypass = 1'b1;
    repeat (2) cycleTick();
    for (int i = 0; i < 4; i++) begin
      cycleTick();
      if (divOut !== 1'b1) bad++;
      atLowPhase();
      if (divOut !== 1'b0) bad++;
    end
    check("R10 bypass follows clock", bad, 0);
    atLowPhase();
    bypass = 1'b0;
    countToEdge(17, "R10 restart after bypass");
  endtask

  initial begin
    testReset();
    testRatio();
    testDuty();
    testHoldRelease();
    testPhase();
    testSoftSync();
    testIgnore();
    testForce();
    testBypass();
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule